// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block sits between a 32-bit instruction fetch port and the decoder of a core that runs both 16-bit compressed and 32-bit instructions. Each accepted fetch word comes with the program counter of the instruction to be extracted from it. That PC may sit on any halfword. The aligner picks the correct halfword and decides the instruction's length from its two lowest bits. It hands one complete instruction at a time to the decoder, together with a compressed flag, the instruction's own PC and the sequential next PC.

A 32-bit instruction that starts in the upper halfword of a fetch word runs into the next word. The aligner keeps that upper half as a pending low half and sets a mid-instruction state. The next word's lower halfword then completes the instruction. The decoder side also supplies the next PC that was actually chosen. The aligner compares it against the sequential step and flags a control transfer. A flush input drops any pending half and any waiting instruction, so a redirect never merges halves from two different paths.

Top module: `fetch_aligner`

## Requirements
- R1: After reset, `out_valid` is 0, `fetch_ready` is 1, `ctl_xfer` and `seq_err` are 0, and `out_insn` holds the no-op value 32'h0000_0013.
- R2: An instruction is full-length when its bits [1:0] equal 2'b11 and compressed otherwise. `out_compressed` is 1 exactly for compressed instructions. A compressed instruction is output zero-extended in `out_insn[15:0]`, with bits [31:16] zero.
- R3: With `fetch_pc[1]`=0, the lower halfword of `fetch_word` is examined. If it is compressed, it is output alone. Otherwise the whole word is output. In both cases `out_pc` equals `fetch_pc`.
- R4: With `fetch_pc[1]`=1 and a compressed upper halfword, that halfword (`fetch_word[31:16]`) is output at once with `out_pc` equal to `fetch_pc`.
- R5: With `fetch_pc[1]`=1 and a full-length upper halfword, no instruction is output. The halfword becomes bits [15:0] of a pending instruction. The next accepted word, with the PC still on the halfword, supplies its lower halfword as bits [31:16]. The joined instruction is output with `out_pc` equal to the PC of its first half.
- R6: `out_seq_npc` equals `out_pc`+2 for a compressed instruction and `out_pc`+4 for a full-length one.
- R7: While `out_valid` is 1, `ctl_xfer` is 1 exactly when `npc_in` differs from `out_seq_npc`. It is 0 whenever `out_valid` is 0.
- R8: An output instruction is presented with `out_valid` and held unchanged until the cycle in which `out_ready` is 1. While it waits, `fetch_ready` is 0 and an offered fetch word is not taken.
- R9: A cycle with `flush`=1 clears any pending half and any waiting instruction, and `fetch_ready` is 0 in that cycle. The next word is handled as a fresh start.
- R10: If a word is accepted while a half is pending but `fetch_pc[1]`=0, `seq_err` is 1 for one cycle. The pending half is dropped, and the word is handled as a fresh word-aligned start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Redirect: drop pending half and waiting instruction |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_ready | output | 1 | Aligner takes the offered word this cycle |
| fetch_word | input | 32 | Fetched instruction word |
| fetch_pc | input | PC_W | PC of the instruction to extract; bit 1 selects the halfword |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | Decoder consumes the presented instruction |
| out_insn | output | 32 | Instruction, compressed ones zero-extended |
| out_compressed | output | 1 | Presented instruction is 16 bits long |
| out_pc | output | PC_W | PC of the presented instruction |
| out_seq_npc | output | PC_W | Sequential next PC |
| npc_in | input | PC_W | Next PC actually chosen downstream |
| ctl_xfer | output | 1 | `npc_in` is not the sequential step |
| seq_err | output | 1 | One-cycle pulse: continuation arrived word-aligned |

## Verification
The assertions assume that `flush` and `out_ready` are driven cleanly from reset. They also assume that `fetch_word` is only consumed through the ready handshake, so the held output is compared only across cycles where nothing may legally replace it. The bench keeps to this by changing inputs only on falling edges and offering a word only when it expects `fetch_ready`. It deliberately offers one word while an instruction waits, to show that the word is refused. The misaligned continuation of R10 is provoked on purpose. The stable-output and flush properties are therefore checked against real back-pressure and redirect cases.

// File: rtl/fetch_aligner_pkg.sv
// Package: shared widths, constants and helpers for the fetch aligner.
// Assumes a fixed 32-bit instruction word split into two halfwords.
package fetch_aligner_pkg;
    localparam int INSN_W = 32;
    localparam int HALF_W = INSN_W / 2;
    localparam logic [INSN_W-1:0] NOP_INSN = 32'h0000_0013;

    // Result of slicing one fetch word.
    typedef struct packed {
        logic [INSN_W-1:0] insn;
        logic              comp;
        logic              done;
        logic              hold;
        logic              err;
    } slice_t;

    // True when a halfword starts a full-length instruction.
    function automatic logic starts_full(input logic [HALF_W-1:0] h);
        return h[1:0] == 2'b11;
    endfunction
endpackage

// File: rtl/fa_slicer.sv
// Module: fa_slicer
// Combinational halfword selection and length decision for one fetch word.
// Assumes mid/pend describe a pending low half from the previous word.
module fa_slicer
    import fetch_aligner_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    input  logic              pc_hi_half,
    input  logic              mid,
    input  logic [HALF_W-1:0] pend,
    output slice_t            res
);
    logic [HALF_W-1:0] lo_h;
    logic [HALF_W-1:0] hi_h;

    assign lo_h = word[HALF_W-1:0];
    assign hi_h = word[INSN_W-1:HALF_W];

    // Pick halfword, decide length, join with pending half when continuing.
    always_comb begin
        res      = '0;
        res.insn = '0;
        res.err  = mid && !pc_hi_half;
        if (mid && pc_hi_half) begin
            res.insn = {lo_h, pend};
            res.done = 1'b1;
        end else if (!pc_hi_half) begin
            if (starts_full(lo_h)) begin
                res.insn = word;
            end else begin
                res.insn = {{HALF_W{1'b0}}, lo_h};
                res.comp = 1'b1;
            end
            res.done = 1'b1;
        end else if (starts_full(hi_h)) begin
            res.hold = 1'b1;
        end else begin
            res.insn = {{HALF_W{1'b0}}, hi_h};
            res.comp = 1'b1;
            res.done = 1'b1;
        end
    end
endmodule

// File: rtl/fa_pc_step.sv
// Module: fa_pc_step
// Computes the sequential next PC and flags a non-sequential chosen PC.
// Assumes pc/comp describe the presented instruction when valid is high.
module fa_pc_step #(
    parameter int PC_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            comp,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] npc_in,
    output logic [PC_W-1:0] seq_npc,
    output logic            taken
);
    localparam logic [PC_W-1:0] STEP_C = PC_W'(2);
    localparam logic [PC_W-1:0] STEP_F = PC_W'(4);

    // Step by instruction length.
    always_comb seq_npc = pc + (comp ? STEP_C : STEP_F);

    // Transfer flag only for a presented instruction.
    always_comb taken = valid && (npc_in != seq_npc);

    p_taken_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> valid);
endmodule

// File: rtl/fetch_aligner.sv
// Module: fetch_aligner (top)
// Extracts one 16- or 32-bit instruction per handshake from 32-bit fetch
// words and rebuilds 32-bit instructions that straddle two words.
// Assumes a continuation word arrives with the PC of the first half.
module fetch_aligner
    import fetch_aligner_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [INSN_W-1:0] fetch_word,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [INSN_W-1:0] out_insn,
    output logic              out_compressed,
    output logic [PC_W-1:0]   out_pc,
    output logic [PC_W-1:0]   out_seq_npc,
    input  logic [PC_W-1:0]   npc_in,
    output logic              ctl_xfer,
    output logic              seq_err
);
    logic              mid_q;
    logic [HALF_W-1:0] pend_q;
    logic [PC_W-1:0]   start_pc_q;
    logic              vld_q;
    logic [INSN_W-1:0] insn_q;
    logic              comp_q;
    logic [PC_W-1:0]   pc_q;
    logic              err_q;
    logic              accept;
    slice_t            sl;

    fa_slicer u_slicer (
        .word       (fetch_word),
        .pc_hi_half (fetch_pc[1]),
        .mid        (mid_q),
        .pend       (pend_q),
        .res        (sl)
    );

    fa_pc_step #(.PC_W(PC_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (vld_q),
        .comp    (comp_q),
        .pc      (pc_q),
        .npc_in  (npc_in),
        .seq_npc (out_seq_npc),
        .taken   (ctl_xfer)
    );

    // Take a word only when nothing waits and no redirect is in progress.
    always_comb fetch_ready = !vld_q && !flush;
    always_comb accept = fetch_valid && fetch_ready;

    // State: pending half, presented instruction, error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q      <= 1'b0;
            pend_q     <= '0;
            start_pc_q <= '0;
            vld_q      <= 1'b0;
            insn_q     <= NOP_INSN;
            comp_q     <= 1'b0;
            pc_q       <= '0;
            err_q      <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (flush) begin
                mid_q  <= 1'b0;
                pend_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                if (vld_q && out_ready) vld_q <= 1'b0;
                if (accept) begin
                    err_q <= sl.err;
                    if (sl.done) begin
                        vld_q  <= 1'b1;
                        insn_q <= sl.insn;
                        comp_q <= sl.comp;
                        pc_q   <= (mid_q && fetch_pc[1]) ? start_pc_q : fetch_pc;
                        mid_q  <= 1'b0;
                    end else if (sl.hold) begin
                        mid_q      <= 1'b1;
                        pend_q     <= fetch_word[INSN_W-1:HALF_W];
                        start_pc_q <= fetch_pc;
                    end
                end
            end
        end
    end

    assign out_valid      = vld_q;
    assign out_insn       = insn_q;
    assign out_compressed = comp_q;
    assign out_pc         = pc_q;
    assign seq_err        = err_q;

    p_held_until_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !out_ready && !flush) |=> (vld_q && $stable(insn_q) && $stable(pc_q)));
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!vld_q && !mid_q));
    p_comp_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && comp_q) |-> (insn_q[INSN_W-1:HALF_W] == '0 && insn_q[1:0] != 2'b11));
    p_full_len_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !comp_q) |-> (insn_q[1:0] == 2'b11));
    p_no_out_while_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_q && vld_q));
    p_err_drops_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !mid_q);
endmodule

// File: tb/fetch_aligner_bench.sv
module fetch_aligner_bench;
    localparam int PC_W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic            fetch_valid = 1'b0;
    logic            fetch_ready;
    logic [31:0]     fetch_word = '0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [31:0]     out_insn;
    logic            out_compressed;
    logic [PC_W-1:0] out_pc;
    logic [PC_W-1:0] out_seq_npc;
    logic [PC_W-1:0] npc_in = '0;
    logic            ctl_xfer;
    logic            seq_err;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fetch_aligner #(.PC_W(PC_W)) u_fetch_aligner (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_word(fetch_word), .fetch_pc(fetch_pc),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_insn(out_insn), .out_compressed(out_compressed),
        .out_pc(out_pc), .out_seq_npc(out_seq_npc),
        .npc_in(npc_in), .ctl_xfer(ctl_xfer), .seq_err(seq_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one word for one edge; outputs observed at the following negedge.
    task automatic send(input logic [31:0] w, input logic [PC_W-1:0] pc);
        @(negedge clk);
        fetch_word  = w;
        fetch_pc    = pc;
        fetch_valid = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic consume();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Check a presented instruction against expected fields.
    task automatic expect_out(input string req, input logic [31:0] insn, input bit comp,
                              input logic [PC_W-1:0] pc);
        chk(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
        chk(out_insn == insn, req, 64'(out_insn), 64'(insn));
        chk(out_compressed == comp, req, 64'(out_compressed), 64'(comp));
        chk(out_pc == pc, req, out_pc, pc);
        chk(out_seq_npc == pc + (comp ? 64'd2 : 64'd4), "R6", out_seq_npc, pc + (comp ? 64'd2 : 64'd4));
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        chk(fetch_ready == 1'b1, "R1", 64'(fetch_ready), 64'd1);
        chk(out_insn == 32'h0000_0013, "R1", 64'(out_insn), 64'h13);
        chk(ctl_xfer == 1'b0 && seq_err == 1'b0, "R1", 64'({ctl_xfer, seq_err}), 64'd0);
    endtask

    task automatic t_aligned();
        send(32'hABCD_4505, 64'h1000);   // low half compressed
        expect_out("R3", 32'h0000_4505, 1'b1, 64'h1000);
        consume();
        send(32'h0040_0093, 64'h1004);   // full word
        expect_out("R3", 32'h0040_0093, 1'b0, 64'h1004);
        consume();
    endtask

    task automatic t_unaligned_comp();
        send(32'h8082_FFFF, 64'h2002);
        expect_out("R4", 32'h0000_8082, 1'b1, 64'h2002);
        consume();
    endtask

    task automatic t_straddle();
        send(32'h0513_0001, 64'h3002);   // upper half 0x0513 full-length
        chk(out_valid == 1'b0, "R5", 64'(out_valid), 64'd0);
        send(32'h1234_0000, 64'h3002);   // continuation low half 0x0000
        expect_out("R5", 32'h0000_0513, 1'b0, 64'h3002);
        chk(out_compressed == 1'b0, "R2", 64'(out_compressed), 64'd0);
        consume();
    endtask

    task automatic t_ctl_xfer();
        send(32'h0000_0001, 64'h4000);
        npc_in = 64'h4002;
        #1;
        chk(ctl_xfer == 1'b0, "R7", 64'(ctl_xfer), 64'd0);
        npc_in = 64'h4004;
        #1;
        chk(ctl_xfer == 1'b1, "R7", 64'(ctl_xfer), 64'd1);
        consume();
        #1;
        chk(ctl_xfer == 1'b0, "R7", 64'(ctl_xfer), 64'd0);
    endtask

    task automatic t_backpressure();
        send(32'h0000_0002, 64'h5000);
        chk(fetch_ready == 1'b0, "R8", 64'(fetch_ready), 64'd0);
        send(32'h00A0_0093, 64'h5002);   // must be refused
        expect_out("R8", 32'h0000_0002, 1'b1, 64'h5000);
        consume();
        chk(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    endtask

    task automatic t_flush();
        send(32'h0013_0000, 64'h6002);   // start pending half
        @(negedge clk); flush = 1'b1;
        #1;
        chk(fetch_ready == 1'b0, "R9", 64'(fetch_ready), 64'd0);
        @(negedge clk); flush = 1'b0;
        send(32'h0000_7FFF, 64'h7002);   // upper half compressed, fresh start
        expect_out("R9", 32'h0000_0000, 1'b1, 64'h7002);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    endtask

    task automatic t_seq_err();
        send(32'h0093_0000, 64'h8002);   // pending
        send(32'hFFFF_0009, 64'h9000);   // aligned while pending
        chk(seq_err == 1'b1, "R10", 64'(seq_err), 64'd1);
        expect_out("R10", 32'h0000_0009, 1'b1, 64'h9000);
        @(negedge clk);
        chk(seq_err == 1'b0, "R10", 64'(seq_err), 64'd0);
        consume();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_aligned();
                t_unaligned_comp();
                t_straddle();
                t_ctl_xfer();
                t_backpressure();
                t_flush();
                t_seq_err();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule